// File: doc/BRIEF.md
# Fast Ethernet 4B/5B Transmit Encoder with Stream Delimiters

This block turns the nibble-wide transmit stream of a 100 Mb/s Ethernet physical layer into 5-bit code groups, producing exactly one code group for every nibble clock. Each data nibble is replaced by its fixed 5-bit code. A small frame sequencer rewrites the edges of each frame. When transmit enable goes high, the first two nibbles of the frame (the leading preamble nibbles) are replaced by the start delimiter pair. When transmit enable goes low, the end delimiter pair is sent and the link then returns to idle. While a frame body is being sent, asserting transmit error replaces the current nibble with the error symbol.

A raw mode switches off all encoding. In raw mode the code group is simply the error bit placed above the four data bits. This lets a test or link-bring-up path drive arbitrary 5-bit patterns. The output is a register, so a nibble presented in one cycle appears as a code group after the next rising clock edge. Scrambling, serialization and line coding take place downstream of this block.

Top module: `fx_tx_encoder`

## Requirements
- R1: In the frame body, with transmit error low, nibble values 0x0 through 0xF are coded as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, respectively (code bit 4 is the MSB).
- R2: After reset, and between frames while transmit enable is low, the output is IDLE (11111). Transmit error has no effect while the link is idle.
- R3: In the cycle where transmit enable is first seen high after idle, the output is J (11000), and in the next cycle it is K (10001). The nibbles and the transmit error values presented in those two cycles are discarded, so a frame takes as many code groups as it has nibbles.
- R4: In the first body cycle where transmit enable is seen low, the output is T (01101). The next cycle outputs R (00111), and after that IDLE follows until transmit enable is high again.
- R5: In a frame-body cycle with transmit error high, the output is H (00100) instead of the coded nibble.
- R6: With raw mode high, the output is {tx_err, tx_nib[3:0]} with no coding, and the sequencer returns to idle. If transmit enable is high in the first cycle after raw mode ends, a new start delimiter begins.
- R7: The output is registered with exactly one clock of latency: the value changes only at a rising clock edge, reflecting the inputs sampled at that edge.
- R8: If transmit enable drops during K, K is still sent and T follows. If transmit enable rises again while R is pending, R is still sent and J follows in the next cycle.
- R9: A synchronous active-high reset forces IDLE on the output at the next edge, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, high for the length of a frame |
| tx_err | input | 1 | Transmit error request |
| tx_nib | input | 4 | Transmit data nibble |
| raw_mode | input | 1 | High to bypass encoding |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
The hardest cases to reach are the frame edges that overlap a pending delimiter. These are transmit enable falling while K is still owed, and transmit enable rising again while R is still owed. Reaching them requires toggling transmit enable on consecutive nibble clocks at exact offsets from the frame start. The vector table places these toggles at cycle-exact positions right after a short frame. It also places an error request on the J and K cycles, to show that the request is dropped there. Directed steps then assert reset in the middle of a frame body and drop raw mode while transmit enable is high.

// File: rtl/fxenc_pkg.sv
package fxenc_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = NIB_W + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam code_t SYM_IDLE = 5'b11111;
  localparam code_t SYM_J    = 5'b11000;
  localparam code_t SYM_K    = 5'b10001;
  localparam code_t SYM_T    = 5'b01101;
  localparam code_t SYM_R    = 5'b00111;
  localparam code_t SYM_H    = 5'b00100;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SSD2,
    PH_BODY,
    PH_ESD2
  } phase_e;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_J,
    SEL_K,
    SEL_DATA,
    SEL_T,
    SEL_R,
    SEL_H
  } sel_e;
endpackage

// File: rtl/fxenc_nib_map.sv
module fxenc_nib_map
  import fxenc_pkg::*;
(
  input  nib_t  nib,
  output code_t code
);
  always_comb begin
    unique case (nib)
      4'h0: code = 5'b11110;
      4'h1: code = 5'b01001;
      4'h2: code = 5'b10100;
      4'h3: code = 5'b10101;
      4'h4: code = 5'b01010;
      4'h5: code = 5'b01011;
      4'h6: code = 5'b01110;
      4'h7: code = 5'b01111;
      4'h8: code = 5'b10010;
      4'h9: code = 5'b10011;
      4'hA: code = 5'b10110;
      4'hB: code = 5'b10111;
      4'hC: code = 5'b11010;
      4'hD: code = 5'b11011;
      4'hE: code = 5'b11100;
      default: code = 5'b11101;
    endcase
  end
endmodule

// File: rtl/fxenc_frame_seq.sv
module fxenc_frame_seq
  import fxenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tx_en,
  input  logic   tx_err,
  input  logic   raw_mode,
  output sel_e   sel,
  output phase_e phase
);
  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    sel      = SEL_IDLE;
    unique case (phase)
      PH_IDLE: begin
        if (tx_en) begin
          sel      = SEL_J;
          phase_nx = PH_SSD2;
        end
      end
      PH_SSD2: begin
        sel      = SEL_K;
        phase_nx = PH_BODY;
      end
      PH_BODY: begin
        if (!tx_en) begin
          sel      = SEL_T;
          phase_nx = PH_ESD2;
        end else if (tx_err) begin
          sel = SEL_H;
        end else begin
          sel = SEL_DATA;
        end
      end
      default: begin
        sel      = SEL_R;
        phase_nx = PH_IDLE;
      end
    endcase
    if (raw_mode) phase_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end

  // R3
  k_follows_j_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SSD2 && !raw_mode) |=> (phase == PH_BODY));

  // R8
  r_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ESD2) |=> (phase == PH_IDLE));

  // R6
  raw_parks_idle_chk: assert property (@(posedge clk) disable iff (rst)
    raw_mode |=> (phase == PH_IDLE));
endmodule

// File: rtl/fx_tx_encoder.sv
module fx_tx_encoder
  import fxenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       tx_err,
  input  logic [3:0] tx_nib,
  input  logic       raw_mode,
  output logic [4:0] code_out
);
  code_t  data_code;
  sel_e   sel;
  phase_e phase;
  code_t  code_nx;
  logic   raw_d;

  fxenc_nib_map u_map (
    .nib  (tx_nib),
    .code (data_code)
  );

  fxenc_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_err   (tx_err),
    .raw_mode (raw_mode),
    .sel      (sel),
    .phase    (phase)
  );

  always_comb begin
    unique case (sel)
      SEL_J:    code_nx = SYM_J;
      SEL_K:    code_nx = SYM_K;
      SEL_DATA: code_nx = data_code;
      SEL_T:    code_nx = SYM_T;
      SEL_R:    code_nx = SYM_R;
      SEL_H:    code_nx = SYM_H;
      default:  code_nx = SYM_IDLE;
    endcase
    if (raw_mode) code_nx = {tx_err, tx_nib};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= SYM_IDLE;
      raw_d    <= 1'b0;
    end else begin
      code_out <= code_nx;
      raw_d    <= raw_mode;
    end
  end

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_d && !raw_mode && code_out == SYM_J) |=> (code_out == SYM_K));

  // R4
  t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_d && !raw_mode && code_out == SYM_T) |=> (code_out == SYM_R));

  // R4
  after_r_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_d && !raw_mode && code_out == SYM_R)
      |=> (code_out == SYM_IDLE || code_out == SYM_J));

  // R6
  raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
    raw_mode |=> (code_out == $past({tx_err, tx_nib})));

  // R5
  err_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_mode && tx_en && tx_err && phase == PH_BODY) |=> (code_out == SYM_H));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_mode && !tx_en && phase == PH_IDLE) |=> (code_out == SYM_IDLE));
endmodule

// File: tb/test_fx_tx_encoder.sv
module test_fx_tx_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic       raw_mode = 1'b0;
  logic [4:0] code_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fx_tx_encoder i_fx_tx_encoder (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_err   (tx_err),
    .tx_nib   (tx_nib),
    .raw_mode (raw_mode),
    .code_out (code_out)
  );

  // entry: {tx_en, tx_err, raw_mode, tx_nib, expected code after the edge}
  localparam int NV = 41;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,1'b0,4'h0,5'b11111}, // R2 idle
    {1'b0,1'b1,1'b0,4'h3,5'b11111}, // R2 error ignored in idle
    {1'b1,1'b0,1'b0,4'h5,5'b11000}, // R3 J
    {1'b1,1'b0,1'b0,4'h5,5'b10001}, // R3 K
    {1'b1,1'b0,1'b0,4'h0,5'b11110}, // R1
    {1'b1,1'b0,1'b0,4'h1,5'b01001},
    {1'b1,1'b0,1'b0,4'h2,5'b10100},
    {1'b1,1'b0,1'b0,4'h3,5'b10101},
    {1'b1,1'b0,1'b0,4'h4,5'b01010},
    {1'b1,1'b0,1'b0,4'h5,5'b01011},
    {1'b1,1'b0,1'b0,4'h6,5'b01110},
    {1'b1,1'b0,1'b0,4'h7,5'b01111},
    {1'b1,1'b0,1'b0,4'h8,5'b10010},
    {1'b1,1'b0,1'b0,4'h9,5'b10011},
    {1'b1,1'b0,1'b0,4'hA,5'b10110},
    {1'b1,1'b0,1'b0,4'hB,5'b10111},
    {1'b1,1'b0,1'b0,4'hC,5'b11010},
    {1'b1,1'b0,1'b0,4'hD,5'b11011},
    {1'b1,1'b0,1'b0,4'hE,5'b11100},
    {1'b1,1'b0,1'b0,4'hF,5'b11101},
    {1'b1,1'b1,1'b0,4'h3,5'b00100}, // R5 H
    {1'b1,1'b0,1'b0,4'hA,5'b10110}, // R5 back to data
    {1'b0,1'b0,1'b0,4'h0,5'b01101}, // R4 T
    {1'b0,1'b0,1'b0,4'h0,5'b00111}, // R4 R
    {1'b0,1'b0,1'b0,4'h0,5'b11111}, // R4 idle
    {1'b1,1'b0,1'b0,4'hD,5'b11000}, // R8 J
    {1'b0,1'b0,1'b0,4'h0,5'b10001}, // R8 K despite drop
    {1'b0,1'b0,1'b0,4'h0,5'b01101}, // R8 T
    {1'b1,1'b0,1'b0,4'h0,5'b00111}, // R8 R despite rise
    {1'b1,1'b0,1'b0,4'h0,5'b11000}, // R8 J
    {1'b1,1'b0,1'b0,4'h0,5'b10001}, // R8 K
    {1'b1,1'b0,1'b0,4'h7,5'b01111}, // R1
    {1'b1,1'b1,1'b1,4'h2,5'b10010}, // R6 raw
    {1'b0,1'b0,1'b1,4'hF,5'b01111}, // R6 raw
    {1'b0,1'b0,1'b0,4'h0,5'b11111}, // R6 idle after raw
    {1'b0,1'b1,1'b0,4'h0,5'b11111}, // R2
    {1'b1,1'b1,1'b0,4'h0,5'b11000}, // R3 error dropped on J
    {1'b1,1'b1,1'b0,4'h0,5'b10001}, // R3 error dropped on K
    {1'b0,1'b0,1'b0,4'h0,5'b01101}, // R4 T
    {1'b0,1'b0,1'b0,4'h0,5'b00111}, // R4 R
    {1'b0,1'b0,1'b0,4'h0,5'b11111}  // R4 idle
  };

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (code_out !== exp) begin
      errors++;
      $display("FAIL %s code_out=%b expected=%b", req, code_out, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic rw, input logic [3:0] nb);
    tx_en = en; tx_err = er; raw_mode = rw; tx_nib = nb;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", 5'b11111);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check($sformatf("R1-table entry %0d", i), VEC[i][4:0]);
    end

    // R9 reset in the middle of a frame body
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b11000);
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b10001);
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b01010);
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b11111);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b11000);
    step(1'b1, 1'b0, 1'b0, 4'h4); check("R9", 5'b10001);

    // R7 output holds between edges, changes at the edge
    tx_nib = 4'h9;
    #2;
    check("R7", 5'b10001);
    @(posedge clk);
    #1;
    check("R7", 5'b10011);
    @(negedge clk);

    // R6 leaving raw mode with enable high starts a new frame
    step(1'b1, 1'b0, 1'b1, 4'h1); check("R6", 5'b00001);
    step(1'b1, 1'b0, 1'b0, 4'h1); check("R6", 5'b11000);
    step(1'b1, 1'b0, 1'b0, 4'h1); check("R6", 5'b10001);
    step(1'b0, 1'b0, 1'b0, 4'h0); check("R4", 5'b01101);
    step(1'b0, 1'b0, 1'b0, 4'h0); check("R4", 5'b00111);
    step(1'b0, 1'b0, 1'b0, 4'h0); check("R2", 5'b11111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule